// File: doc/BRIEF.md
# Host Adapter Message Queue and Interrupt Unit

This block sits between a host processor and the message engine of a storage host adapter. The host writes request frame addresses into a request queue, and the engine drains that queue. The host also supplies empty reply buffer addresses. When the engine finishes a message it posts a completion token, which the host reads back from a reply queue. A completion comes in one of two forms. A full-frame reply uses up one host-supplied buffer and posts that buffer's address in encoded form. A turbo reply posts the message context alone.

The unit keeps interrupt status and mask bits and drives a level interrupt. It also keeps a state word. When a queue cannot accept or supply an entry, the state word latches a sticky fault with an out-of-resources code. The host reaches everything through a 32-bit, word-addressed register port. Read data appears one cycle after the read strobe. Word addresses: 0 state/control, 1 interrupt status, 2 interrupt mask, 3 request post, 4 free buffer, 5 reply post.

Each queue is a circular buffer with one slot held empty. A queue with ENTRIES usable entries therefore has ENTRIES+1 slots, and the default is 128 usable entries.

Top module: `mq_unit`

## Requirements
- R1: After reset, the state word reads 0x1000_0000 (READY), interrupt status reads 0, the mask reads 0x9, irq is low, req_valid is low and a reply-post read returns 0xFFFF_FFFF.
- R2: A host write to word 3 queues the value with bits 1:0 forced to zero. req_valid/req_addr present the oldest entry, and req_take removes it.
- R3: Every queue holds exactly ENTRIES entries. A host write to a full request or free-buffer queue is dropped and raises the fault.
- R4: A frame reply (frame_req) removes the oldest free buffer address A and posts 0x8000_0000 | (A >> 1). It sets interrupt status bit 3.
- R5: A frame reply when the free-buffer queue is empty or the reply queue is full changes no queue and raises the fault.
- R6: A turbo reply (turbo_req, ignored while frame_req is high) posts turbo_ctx with bit 31 cleared and sets status bit 3. When the reply queue is full, it raises the fault instead.
- R7: A host read of word 5 returns the oldest reply token and removes it. When the queue is empty, the read returns 0xFFFF_FFFF and clears status bit 3.
- R8: irq is high exactly when status bit 0 (doorbell) or bit 3 (reply) is set and its mask bit is clear. Status bit 31 follows iop_busy one cycle late and never raises irq.
- R9: Only mask bits 0 and 3 are writable. All other mask bits read as zero.
- R10: A db_event pulse sets status bit 0. Any host write to word 1 clears bit 0 and leaves bit 3 unchanged.
- R11: A fault sets the state word to 0x4000_0006, but only when no fault is already latched. The first fault holds until a soft reset.
- R12: Writing word 0 with bit 0 set performs a soft reset. It empties all three queues, clears interrupt status and returns the state word to READY. The mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid the cycle after host_rd |
| host_rvalid | output | 1 | Read data valid |
| req_valid | output | 1 | Request queue not empty |
| req_addr | output | 32 | Oldest request frame address |
| req_take | input | 1 | Engine removes the oldest request |
| frame_req | input | 1 | Post a full-frame reply |
| turbo_req | input | 1 | Post a context-only reply |
| turbo_ctx | input | 32 | Message context for a turbo reply |
| db_event | input | 1 | Doorbell event, sets status bit 0 |
| iop_busy | input | 1 | Engine busy level, mirrored in status bit 31 |
| irq | output | 1 | Level interrupt |

## Verification
The assertions rely on several input conventions. The host never reads and writes in the same cycle. frame_req and turbo_req are never high together. Every write to a queue, and every pop, goes through the unit's own full and empty gating, so the buffers themselves never overflow or underflow. The bench drives exactly one strobe per cycle, and it never pulses a host strobe and an engine request in the same cycle. Its random phase mixes free-buffer writes, both reply kinds, reply reads and status reads, and it checks each of them against a queue model kept in the bench. Directed sequences then fill each queue to its limit and one entry beyond.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam logic [31:0] ST_READY    = 32'h1000_0000;
    localparam logic [31:0] ST_FAULT    = 32'h4000_0000;
    localparam int          FAULT_BIT   = 30;
    localparam logic [15:0] CODE_NO_RES = 16'h0006;

    localparam logic [31:0] IS_DB    = 32'h0000_0001;
    localparam logic [31:0] IS_REPLY = 32'h0000_0008;
    localparam logic [31:0] IS_BUSY  = 32'h8000_0000;
    localparam logic [31:0] MASK_WR  = IS_DB | IS_REPLY;

    localparam logic [31:0] TOKEN_ADDR_FLAG = 32'h8000_0000;

    localparam logic [2:0] A_STATE = 3'd0;
    localparam logic [2:0] A_ISTAT = 3'd1;
    localparam logic [2:0] A_IMASK = 3'd2;
    localparam logic [2:0] A_REQ   = 3'd3;
    localparam logic [2:0] A_FREE  = 3'd4;
    localparam logic [2:0] A_POST  = 3'd5;

    typedef struct packed {
        logic [31:0] state;
        logic [31:0] rdata;
        logic        rvalid;
    } top_s;

    typedef struct packed {
        logic [31:0] status;
        logic [31:0] mask;
    } irq_s;
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
    parameter int ENTRIES = 128,
    parameter int W       = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int SLOTS = ENTRIES + 1;
    localparam int PW    = $clog2(SLOTS);
    localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
    } ptr_s;

    ptr_s        p_d, p_q;
    logic [W-1:0] mem_q [SLOTS];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty = (p_q.head == p_q.tail);
    assign full  = (p_q.head == step(p_q.tail));
    assign rdata = mem_q[p_q.head];

    always_comb begin
        p_d = p_q;
        if (clr) begin
            p_d = '0;
        end else begin
            if (push) p_d.tail = step(p_q.tail);
            if (pop)  p_d.head = step(p_q.head);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[p_q.tail] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7
endmodule

// File: rtl/mq_irq.sv
module mq_irq
    import mq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        set_reply,
    input  logic        clr_reply,
    input  logic        set_db,
    input  logic        clr_db,
    input  logic        busy,
    input  logic        mask_we,
    input  logic [31:0] mask_wdata,
    output logic [31:0] status,
    output logic [31:0] mask,
    output logic        irq
);
    irq_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mask_we) r_d.mask = mask_wdata & MASK_WR;
        if (clr_db)    r_d.status[0] = 1'b0;
        if (set_db)    r_d.status[0] = 1'b1;
        if (clr_reply) r_d.status[3] = 1'b0;
        if (set_reply) r_d.status[3] = 1'b1;
        r_d.status[31] = busy;
        if (soft_rst) r_d.status = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.status <= '0;
            r_q.mask   <= MASK_WR;
        end else begin
            r_q <= r_d;
        end
    end

    assign status = r_q.status;
    assign mask   = r_q.mask;
    assign irq    = |(r_q.status & ~(r_q.mask | IS_BUSY));

    AST_MASK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask & ~MASK_WR) == '0); // R9
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.status & ~IS_BUSY) == '0) |-> !irq); // R8
endmodule

// File: rtl/mq_unit.sv
module mq_unit
    import mq_pkg::*;
#(
    parameter int ENTRIES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_rvalid,
    output logic        req_valid,
    output logic [31:0] req_addr,
    input  logic        req_take,
    input  logic        frame_req,
    input  logic        turbo_req,
    input  logic [31:0] turbo_ctx,
    input  logic        db_event,
    input  logic        iop_busy,
    output logic        irq
);
    top_s st_d, st_q;

    logic        req_empty, req_full, free_empty, free_full, post_empty, post_full;
    logic [31:0] req_rdata, free_rdata, post_rdata, post_wdata;
    logic [31:0] istat, imask;

    logic wr_state, wr_istat, wr_imask, wr_req, wr_free, rd_post;
    logic soft_rst;
    logic req_push, req_pop, free_push, free_pop, post_push, post_pop;
    logic frame_ok, turbo_go, any_fault;

    always_comb begin
        wr_state = host_wr && (host_addr == A_STATE);
        wr_istat = host_wr && (host_addr == A_ISTAT);
        wr_imask = host_wr && (host_addr == A_IMASK);
        wr_req   = host_wr && (host_addr == A_REQ);
        wr_free  = host_wr && (host_addr == A_FREE);
        rd_post  = host_rd && (host_addr == A_POST);
        soft_rst = wr_state && host_wdata[0];

        req_push  = wr_req && !req_full;
        req_pop   = req_take && !req_empty;
        free_push = wr_free && !free_full;

        frame_ok  = frame_req && !free_empty && !post_full;
        turbo_go  = turbo_req && !frame_req && !post_full;
        free_pop  = frame_ok;
        post_push = frame_ok || turbo_go;
        post_pop  = rd_post && !post_empty;
        post_wdata = frame_ok ? (TOKEN_ADDR_FLAG | (free_rdata >> 1))
                              : (turbo_ctx & ~TOKEN_ADDR_FLAG);

        any_fault = (wr_req && req_full) || (wr_free && free_full) ||
                    (frame_req && !frame_ok) ||
                    (turbo_req && !frame_req && post_full);
    end

    always_comb begin
        st_d = st_q;
        st_d.rvalid = host_rd;
        st_d.rdata  = '0;
        if (host_rd) begin
            case (host_addr)
                A_STATE: st_d.rdata = st_q.state;
                A_ISTAT: st_d.rdata = istat;
                A_IMASK: st_d.rdata = imask;
                A_POST:  st_d.rdata = post_empty ? '1 : post_rdata;
                default: st_d.rdata = '0;
            endcase
        end
        if (soft_rst) begin
            st_d.state = ST_READY;
        end else if (any_fault && !st_q.state[FAULT_BIT]) begin
            st_d.state = ST_FAULT | {16'h0, CODE_NO_RES};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= ST_READY;
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    mq_fifo #(.ENTRIES(ENTRIES), .W(32)) u_req (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(req_push), .pop(req_pop),
        .wdata(host_wdata & ~32'h3), .rdata(req_rdata), .empty(req_empty), .full(req_full));

    mq_fifo #(.ENTRIES(ENTRIES), .W(32)) u_free (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(free_push), .pop(free_pop),
        .wdata(host_wdata), .rdata(free_rdata), .empty(free_empty), .full(free_full));

    mq_fifo #(.ENTRIES(ENTRIES), .W(32)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(post_push), .pop(post_pop),
        .wdata(post_wdata), .rdata(post_rdata), .empty(post_empty), .full(post_full));

    mq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_reply(post_push), .clr_reply(rd_post && post_empty),
        .set_db(db_event), .clr_db(wr_istat), .busy(iop_busy),
        .mask_we(wr_imask), .mask_wdata(host_wdata),
        .status(istat), .mask(imask), .irq(irq));

    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
    assign req_valid   = !req_empty;
    assign req_addr    = req_rdata;

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00)); // R2
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.state[FAULT_BIT]) && !$past(soft_rst)) |-> (st_q.state == $past(st_q.state))); // R11
    AST_EMPTY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_post && post_empty) |-> (host_rdata == 32'hFFFF_FFFF)); // R7
    AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_req && turbo_req)); // R6
    AST_RST_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (st_q.state == ST_READY && req_empty && post_empty)); // R12
endmodule

// File: tb/mq_unit_test.sv
module mq_unit_test;
    localparam int N = 128;
    localparam logic [31:0] READY = 32'h1000_0000;
    localparam logic [31:0] FLT   = 32'h4000_0006;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 0, host_wr = 0;
    logic [2:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        host_rvalid, req_valid, irq;
    logic [31:0] req_addr;
    logic        req_take = 0, frame_req = 0, turbo_req = 0, db_event = 0, iop_busy = 0;
    logic [31:0] turbo_ctx = 0;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_req[$], m_free[$], m_post[$];
    logic [31:0] e_state = READY, e_mask = 32'h9;
    logic e_db = 0, e_reply = 0;

    always #4 clk = ~clk;

    mq_unit #(.ENTRIES(N)) uut (.*);

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [31:0] tok(input logic [31:0] a);
        return 32'h8000_0000 | (a >> 1);
    endfunction

    function automatic logic exp_irq();
        return (e_db && !e_mask[0]) || (e_reply && !e_mask[3]);
    endfunction

    task automatic fault();
        if (!e_state[30]) e_state = FLT;
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); host_rd = 1; host_addr = a;
        @(negedge clk); host_rd = 0; d = host_rdata;
    endtask

    task automatic soft_reset();
        hwrite(3'd0, 32'h1);
        m_req.delete(); m_free.delete(); m_post.delete();
        e_state = READY; e_db = 0; e_reply = 0;
    endtask

    task automatic do_req(input logic [31:0] v);
        hwrite(3'd3, v);
        if (m_req.size() == N) fault(); else m_req.push_back(v & ~32'h3);
    endtask

    task automatic do_free(input logic [31:0] v);
        hwrite(3'd4, v);
        if (m_free.size() == N) fault(); else m_free.push_back(v);
    endtask

    task automatic do_take();
        check("R2 req_valid", {31'b0, req_valid}, {31'b0, m_req.size() != 0});
        if (m_req.size() != 0) check("R2 req_addr", req_addr, m_req[0]);
        @(negedge clk); req_take = 1;
        @(negedge clk); req_take = 0;
        if (m_req.size() != 0) void'(m_req.pop_front());
    endtask

    task automatic do_frame();
        @(negedge clk); frame_req = 1;
        @(negedge clk); frame_req = 0;
        if (m_free.size() == 0 || m_post.size() == N) fault();
        else begin m_post.push_back(tok(m_free.pop_front())); e_reply = 1; end
    endtask

    task automatic do_turbo(input logic [31:0] c);
        @(negedge clk); turbo_req = 1; turbo_ctx = c;
        @(negedge clk); turbo_req = 0;
        if (m_post.size() == N) fault();
        else begin m_post.push_back(c & 32'h7FFF_FFFF); e_reply = 1; end
    endtask

    task automatic do_post_read();
        logic [31:0] d;
        hread(3'd5, d);
        if (m_post.size() == 0) begin
            e_reply = 0;
            check("R7 empty read", d, 32'hFFFF_FFFF);
        end else begin
            logic [31:0] e;
            e = m_post.pop_front();
            if (e[31]) check("R4 frame token", d, e);
            else       check("R6 turbo token", d, e);
        end
    endtask

    task automatic check_regs(input string r);
        logic [31:0] d;
        hread(3'd0, d); check({r, " R11 state"}, d, e_state);
        hread(3'd1, d); check({r, " R10 istat"}, d, {iop_busy, 27'b0, e_reply, 2'b0, e_db});
        check({r, " R8 irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        hread(3'd0, d); check("R1 state", d, READY);
        hread(3'd1, d); check("R1 istat", d, 0);
        hread(3'd2, d); check("R1 mask", d, 32'h9);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 req_valid", {31'b0, req_valid}, 0);
        hread(3'd5, d); check("R1 post empty", d, 32'hFFFF_FFFF);

        // R2 low bits cleared, order
        do_req(32'h1234_5677); do_req(32'hABCD_EF01); do_req(32'h0000_0042);
        repeat (4) do_take();

        // R3 capacity of request queue + R11 fault
        for (int i = 0; i < N + 1; i++) do_req($urandom);
        check_regs("R3 req overflow");
        do_req(32'h10);  // further fault keeps first code (R11)
        hread(3'd0, d); check("R11 sticky", d, FLT);
        for (int i = 0; i < N + 1; i++) do_take();

        // R12 soft reset keeps mask
        hwrite(3'd2, 32'h0); e_mask = 0;
        do_free(32'h100);
        soft_reset();
        check_regs("R12 after reset");
        hread(3'd2, d); check("R12 mask kept", d, 0);
        check("R12 req empty", {31'b0, req_valid}, 0);
        do_frame();                          // free queue cleared -> fault (R5)
        check_regs("R5 frame empty free");
        do_post_read();
        soft_reset();

        // R9 mask write bits
        hwrite(3'd2, 32'hFFFF_FFFF); hread(3'd2, d); check("R9 mask ones", d, 32'h9);
        hwrite(3'd2, 32'h0);         hread(3'd2, d); check("R9 mask zero", d, 32'h0);
        e_mask = 0;

        // R10 / R8 doorbell and busy
        @(negedge clk); db_event = 1; @(negedge clk); db_event = 0; e_db = 1;
        check_regs("R10 db set");
        do_turbo(32'h5);
        hwrite(3'd1, 32'h0); e_db = 0;
        check_regs("R10 db clear keeps reply");
        do_post_read(); do_post_read();
        iop_busy = 1; @(negedge clk);
        check_regs("R8 busy no irq");
        iop_busy = 0; @(negedge clk);
        hwrite(3'd2, 32'h1); e_mask = 32'h1;
        @(negedge clk); db_event = 1; @(negedge clk); db_event = 0; e_db = 1;
        check_regs("R8 db masked");
        hwrite(3'd2, 32'h8); e_mask = 32'h8;
        check_regs("R8 db unmasked");
        hwrite(3'd1, 32'h0); e_db = 0;
        hwrite(3'd2, 32'h0); e_mask = 0;

        // Random mix (R4 R6 R7 R8)
        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 4))
                0: do_free($urandom & 32'hFFFF_FFF0);
                1: do_frame();
                2: do_turbo($urandom);
                3: do_post_read();
                default: check_regs("R8 random");
            endcase
        end
        check_regs("R4 random end");
        soft_reset();

        // R6 reply queue full via turbo
        for (int i = 0; i < N + 1; i++) do_turbo($urandom);
        check_regs("R6 post overflow");
        soft_reset();
        // R5 frame with full reply queue leaves free queue intact
        do_free(32'h0000_2000);
        for (int i = 0; i < N; i++) do_turbo(i);
        do_frame();
        check_regs("R5 frame post full");
        do_post_read();
        do_frame();
        for (int i = 0; i < N + 1; i++) do_post_read();
        check_regs("R7 drained");
        soft_reset();
        check_regs("R12 final");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule